// File: doc/BRIEF.md
# Smart Card Contact Sequencer

This block sets the order in which the contact lines of an ISO 7816 card slot are switched on and off. When software sets the session request, a card is present and the supply is healthy, the block brings the contacts up one stage at a time: supply, data line, clock, and then release of card reset. When the request is cleared, it takes them down in the opposite order. Every step waits for a slow tick taken from the system clock by a fixed divider.

During a session the block watches for card removal, a supply alarm and a short-circuit flag. Any of these starts an emergency shutdown. The first contact step happens on the next clock, without waiting for a tick. The OFF status bit then drops and the interrupt line is raised.

The OFF bit otherwise follows card presence, and presence polarity is a parameter. When the presence interrupt is enabled, every change of the OFF bit raises the interrupt. Reading the status clears it. After any shutdown, a new session needs the request to be cleared and then set again.

Top module: `card_seq_top`

## Requirements
- R1: Successive contact steps, up or down, are exactly DIV_RATIO clock cycles apart. Only an emergency step ignores this spacing.
- R2: A session starts only if the request is 1, the card is present and supply_alarm is 0. Otherwise vcc_en stays 0.
- R3: Activation raises vcc_en, then io_en, then clk_en, then card_rst_n, one step at a time.
- R4: Clearing the request lowers card_rst_n, then clk_en, then io_en, then vcc_en, one step at a time.
- R5: After any shutdown, no new session starts until the request has been seen at 0 with all contacts off and is then set to 1 again.
- R6: During a session, card removal, supply_alarm=1 or short_det=1 removes the next contact stage within two clock cycles, without waiting for a tick. The remaining stages follow at normal step spacing.
- R7: After an emergency shutdown, off_bit is 0 and irq is 1, even while the card is still present. off_bit returns to the presence state once the request is cleared.
- R8: A one-cycle pulse on status_rd clears irq.
- R9: When off_irq_en is 1, any change of off_bit sets irq. When it is 0, a change of off_bit alone leaves irq at 0.
- R10: With PRES_ACT_HIGH=1, pres_pin=1 means a card is present. With PRES_ACT_HIGH=0, pres_pin=0 means present. With no emergency pending, off_bit equals the presence state.
- R11: After reset, all contact outputs, off_bit and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_req | input | 1 | Session request bit from the control register |
| pres_pin | input | 1 | Card presence pin; polarity set by PRES_ACT_HIGH |
| supply_alarm | input | 1 | 1 when the supply voltage is out of range |
| short_det | input | 1 | 1 when a short circuit is detected on the card supply |
| off_irq_en | input | 1 | Enables an interrupt on every change of off_bit |
| status_rd | input | 1 | Pulse marking a status read; clears irq |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card data line enable |
| clk_en | output | 1 | Card clock enable |
| card_rst_n | output | 1 | Card reset, 1 = released |
| off_bit | output | 1 | Presence status, forced to 0 after an emergency |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a request that is cleared and then set again while the contacts are still stepping down. The block must finish the shutdown and then stay off, and nothing is visible at the ports until long after the re-set. The stimulus gets there by waiting for card_rst_n to fall and then setting the request again at once. It then watches vcc_en over many ticks, and finally toggles the request to show that the block re-arms. Emergency shutdowns are driven from the full-on state. The first contact step is sampled before the next tick could have occurred, which separates the immediate step from a tick-driven one.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    // Number of contact stages: supply, data line, clock, reset release
    localparam int STAGES = 4;
    localparam int LVL_W  = 3;

    typedef enum logic [1:0] {
        M_IDLE,
        M_UP,
        M_RUN,
        M_DOWN
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e          mode;
        logic [LVL_W-1:0]   level;
        logic               need_rel;
        logic               emerg;
    } ctrl_st_t;

    typedef struct packed {
        logic pres;
        logic off;
        logic irq;
        logic emerg_seen;
    } mon_st_t;

endpackage

// File: rtl/card_seq_tick.sv
module card_seq_tick #(
    parameter int DIV_RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

    generate
        if (DIV_RATIO > 1) begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == CW'(DIV_RATIO - 1)) cnt_d = '0;
                else                             cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == CW'(DIV_RATIO - 1));

            // R1: two ticks are never adjacent
            p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_nodiv
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
    import card_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sess_req_i,
    input  logic pres_i,
    input  logic alarm_i,
    input  logic short_i,
    output logic vcc_en_o,
    output logic io_en_o,
    output logic clk_en_o,
    output logic rst_rel_o,
    output logic emerg_o
);

    ctrl_st_t st_d, st_q;
    logic     fault;
    logic     in_session;
    logic [STAGES-1:0] stage_on;

    assign fault      = !pres_i || alarm_i || short_i;
    assign in_session = (st_q.mode == M_UP) || (st_q.mode == M_RUN);

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            M_IDLE: begin
                if (!sess_req_i) begin
                    st_d.need_rel = 1'b0;
                    st_d.emerg    = 1'b0;
                end else if (tick_i && !st_q.need_rel && pres_i && !alarm_i) begin
                    st_d.mode  = M_UP;
                    st_d.level = LVL_W'(1);
                end
            end
            M_UP, M_RUN: begin
                if (fault) begin
                    st_d.emerg    = 1'b1;
                    st_d.need_rel = 1'b1;
                    st_d.level    = st_q.level - 1'b1;
                    st_d.mode     = (st_q.level == LVL_W'(1)) ? M_IDLE : M_DOWN;
                end else if (tick_i) begin
                    if (!sess_req_i) begin
                        st_d.need_rel = 1'b1;
                        st_d.level    = st_q.level - 1'b1;
                        st_d.mode     = (st_q.level == LVL_W'(1)) ? M_IDLE : M_DOWN;
                    end else if (st_q.mode == M_UP) begin
                        st_d.level = st_q.level + 1'b1;
                        if (st_q.level == LVL_W'(STAGES - 1)) st_d.mode = M_RUN;
                    end
                end
            end
            M_DOWN: begin
                if (tick_i) begin
                    st_d.level = st_q.level - 1'b1;
                    if (st_q.level == LVL_W'(1)) st_d.mode = M_IDLE;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_IDLE, level: '0, need_rel: 1'b0, emerg: 1'b0};
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            assign stage_on[g] = (st_q.level > LVL_W'(g));
        end
    endgenerate

    assign vcc_en_o  = stage_on[0];
    assign io_en_o   = stage_on[1];
    assign clk_en_o  = stage_on[2];
    assign rst_rel_o = stage_on[3];
    assign emerg_o   = st_q.emerg;

    // R1: the level moves by at most one stage per clock
    p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.level) |->
            (st_q.level == $past(st_q.level) + 1'b1) || (st_q.level == $past(st_q.level) - 1'b1));

    // R1: rising steps happen only on a tick
    p_rise_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level > $past(st_q.level)) |-> $past(tick_i));

    // R2: a session opens only under a request, a present card and a quiet alarm
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level == LVL_W'(1) && $past(st_q.level) == '0) |->
            $past(sess_req_i && pres_i && !alarm_i));

    // R6: a fault in session drops a stage on the very next clock
    p_fault_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_session && fault) |=> (st_q.level < $past(st_q.level)));

endmodule

// File: rtl/card_seq_mon.sv
module card_seq_mon
    import card_seq_pkg::*;
#(
    parameter bit PRES_ACT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pres_pin_i,
    input  logic emerg_i,
    input  logic irq_en_i,
    input  logic status_rd_i,
    output logic pres_o,
    output logic off_o,
    output logic irq_o
);

    mon_st_t st_d, st_q;
    logic    irq_set;

    always_comb begin
        st_d            = st_q;
        st_d.pres       = PRES_ACT_HIGH ? pres_pin_i : !pres_pin_i;
        st_d.off        = st_q.pres && !emerg_i;
        st_d.emerg_seen = emerg_i;
        irq_set         = (irq_en_i && (st_d.off != st_q.off)) ||
                          (emerg_i && !st_q.emerg_seen);
        st_d.irq        = irq_set || (st_q.irq && !status_rd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pres_o = st_q.pres;
    assign off_o  = st_q.off;
    assign irq_o  = st_q.irq;

    // R7: a fresh emergency always raises the interrupt
    p_emerg_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (emerg_i && !st_q.emerg_seen) |=> st_q.irq);

    // R8: the interrupt only falls after a status read
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.irq) |-> $past(status_rd_i));

endmodule

// File: rtl/card_seq_top.sv
module card_seq_top #(
    parameter int DIV_RATIO     = 16,
    parameter bit PRES_ACT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sess_req,
    input  logic pres_pin,
    input  logic supply_alarm,
    input  logic short_det,
    input  logic off_irq_en,
    input  logic status_rd,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic card_rst_n,
    output logic off_bit,
    output logic irq
);

    logic tick;
    logic pres;
    logic emerg;

    card_seq_tick #(.DIV_RATIO(DIV_RATIO)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    card_seq_mon #(.PRES_ACT_HIGH(PRES_ACT_HIGH)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .pres_pin_i  (pres_pin),
        .emerg_i     (emerg),
        .irq_en_i    (off_irq_en),
        .status_rd_i (status_rd),
        .pres_o      (pres),
        .off_o       (off_bit),
        .irq_o       (irq)
    );

    card_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .sess_req_i (sess_req),
        .pres_i     (pres),
        .alarm_i    (supply_alarm),
        .short_i    (short_det),
        .vcc_en_o   (vcc_en),
        .io_en_o    (io_en),
        .clk_en_o   (clk_en),
        .rst_rel_o  (card_rst_n),
        .emerg_o    (emerg)
    );

endmodule

// File: tb/card_seq_top_test.sv
module card_seq_top_test;

    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sess_req = 1'b0, pres_pin = 1'b0, supply_alarm = 1'b0, short_det = 1'b0;
    logic off_irq_en = 1'b0, status_rd = 1'b0;
    logic vcc_en, io_en, clk_en, card_rst_n, off_bit, irq;
    logic lo_vcc, lo_io, lo_clk, lo_rst, lo_off, lo_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    card_seq_top #(.DIV_RATIO(DIV), .PRES_ACT_HIGH(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .sess_req(sess_req), .pres_pin(pres_pin),
        .supply_alarm(supply_alarm), .short_det(short_det), .off_irq_en(off_irq_en),
        .status_rd(status_rd), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
        .card_rst_n(card_rst_n), .off_bit(off_bit), .irq(irq)
    );

    card_seq_top #(.DIV_RATIO(DIV), .PRES_ACT_HIGH(1'b0)) uut_lo (
        .clk(clk), .rst_n(rst_n), .sess_req(1'b0), .pres_pin(pres_pin),
        .supply_alarm(1'b0), .short_det(1'b0), .off_irq_en(1'b0),
        .status_rd(1'b0), .vcc_en(lo_vcc), .io_en(lo_io), .clk_en(lo_clk),
        .card_rst_n(lo_rst), .off_bit(lo_off), .irq(lo_irq)
    );

    // {pres_pin, supply_alarm, sess_req, expected vcc_en}
    localparam logic [3:0] VEC [4] = '{4'b1011, 4'b0010, 4'b1110, 4'b1000};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] pins();
        return {vcc_en, io_en, clk_en, card_rst_n};
    endfunction

    task automatic wait_full();
        for (int i = 0; i < 40 * DIV && !card_rst_n; i++) @(negedge clk);
    endtask

    task automatic wait_vcc();
        for (int i = 0; i < 40 * DIV && !vcc_en; i++) @(negedge clk);
    endtask

    task automatic wait_drop();
        for (int i = 0; i < 40 * DIV && card_rst_n; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            report();
        end
    end

    initial begin
        cyc(3);
        // R11: reset state
        chk("R11 contacts", {28'd0, pins()}, 32'd0);
        chk("R11 off_bit", {31'd0, off_bit}, 32'd0);
        chk("R11 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        cyc(2);

        // R2: activation gating table
        for (int v = 0; v < 4; v++) begin
            pres_pin     = VEC[v][3];
            supply_alarm = VEC[v][2];
            sess_req     = VEC[v][1];
            cyc(3 * DIV);
            chk($sformatf("R2 vec%0d", v), {31'd0, vcc_en}, {31'd0, VEC[v][0]});
            sess_req = 1'b0; pres_pin = 1'b1; supply_alarm = 1'b0;
            cyc(6 * DIV);
        end

        // R3 / R1: activation order and step spacing
        sess_req = 1'b1;
        wait_vcc();
        chk("R3 step1", {28'd0, pins()}, 32'b1000);
        cyc(DIV);
        chk("R3 R1 step2", {28'd0, pins()}, 32'b1100);
        cyc(DIV);
        chk("R3 R1 step3", {28'd0, pins()}, 32'b1110);
        cyc(DIV);
        chk("R3 R1 step4", {28'd0, pins()}, 32'b1111);

        // R4: normal deactivation order
        sess_req = 1'b0;
        wait_drop();
        chk("R4 step1", {28'd0, pins()}, 32'b1110);
        cyc(DIV);
        chk("R4 step2", {28'd0, pins()}, 32'b1100);
        cyc(DIV);
        chk("R4 step3", {28'd0, pins()}, 32'b1000);
        cyc(DIV);
        chk("R4 step4", {28'd0, pins()}, 32'b0000);

        // R5: request re-set during shutdown does not restart
        cyc(2);
        sess_req = 1'b1;
        wait_full();
        sess_req = 1'b0;
        wait_drop();
        sess_req = 1'b1;
        cyc(10 * DIV);
        chk("R5 no restart", {31'd0, vcc_en}, 32'd0);
        sess_req = 1'b0;
        cyc(2);
        sess_req = 1'b1;
        cyc(3 * DIV);
        chk("R5 rearm", {31'd0, vcc_en}, 32'd1);

        // R6 / R7: emergency on card removal
        wait_full();
        pres_pin = 1'b0;
        cyc(2);
        chk("R6 removal first step", {28'd0, pins()}, 32'b1110);
        cyc(6 * DIV);
        chk("R6 removal all off", {28'd0, pins()}, 32'd0);
        chk("R7 removal off_bit", {31'd0, off_bit}, 32'd0);
        chk("R7 removal irq", {31'd0, irq}, 32'd1);
        pres_pin = 1'b1;
        cyc(6 * DIV);
        chk("R5 no restart after fault", {31'd0, vcc_en}, 32'd0);
        chk("R7 off held low", {31'd0, off_bit}, 32'd0);
        status_rd = 1'b1; cyc(1); status_rd = 1'b0; cyc(1);
        chk("R8 clear", {31'd0, irq}, 32'd0);
        sess_req = 1'b0;
        cyc(4);
        chk("R7 off restored", {31'd0, off_bit}, 32'd1);
        chk("R9 disabled toggle", {31'd0, irq}, 32'd0);

        // R6 / R7 / R9: emergency on supply alarm, interrupt enabled
        off_irq_en = 1'b1;
        sess_req = 1'b1;
        wait_full();
        supply_alarm = 1'b1;
        cyc(1);
        chk("R6 alarm first step", {28'd0, pins()}, 32'b1110);
        cyc(6 * DIV);
        chk("R7 alarm off_bit", {31'd0, off_bit}, 32'd0);
        chk("R7 alarm irq", {31'd0, irq}, 32'd1);
        supply_alarm = 1'b0;
        status_rd = 1'b1; cyc(1); status_rd = 1'b0; cyc(1);
        chk("R8 clear2", {31'd0, irq}, 32'd0);
        sess_req = 1'b0;
        cyc(4);
        chk("R9 enabled toggle", {31'd0, irq}, 32'd1);
        status_rd = 1'b1; cyc(1); status_rd = 1'b0; cyc(1);

        // R6: emergency on short circuit
        sess_req = 1'b1;
        wait_full();
        short_det = 1'b1;
        cyc(1);
        chk("R6 short first step", {28'd0, pins()}, 32'b1110);
        cyc(6 * DIV);
        chk("R6 short all off", {28'd0, pins()}, 32'd0);
        short_det = 1'b0;
        sess_req = 1'b0;
        cyc(4);

        // R10: presence polarity
        pres_pin = 1'b1;
        cyc(4);
        chk("R10 high pin hi-pol", {31'd0, off_bit}, 32'd1);
        chk("R10 high pin lo-pol", {31'd0, lo_off}, 32'd0);
        pres_pin = 1'b0;
        cyc(4);
        chk("R10 low pin hi-pol", {31'd0, off_bit}, 32'd0);
        chk("R10 low pin lo-pol", {31'd0, lo_off}, 32'd1);

        done = 1'b1;
        report();
    end

endmodule